// File: doc/BRIEF.md
# Reed-Solomon 12-bit Symbol Error Applier

This block sits after a Reed-Solomon decoder that has already found error locations and error values for one flash page. It takes up to four (position, pattern) pairs and corrects them in place in a byte-addressed page buffer. The buffer holds the data bytes followed directly by the spare bytes in one linear address space. The 12-bit code symbols are packed back to back across that buffer, most significant bit first. The first symbol is short and carries only eight data bits. Every later symbol starts four bits before a byte boundary or exactly on one, so each correction changes either one whole byte or a byte plus a nibble.

A page begins with a `start` pulse that carries the number of pairs. The pairs then follow one per cycle, each qualified by `pair_valid`. Once every pair has been collected, all of them are validated together. If any pair is illegal, the page is declared uncorrectable and the buffer is left untouched. Otherwise each affected byte is corrected with a read cycle followed by a write cycle. A one-cycle `done` pulse carries the fail flag and the number of corrected symbols.

Top module: `rs12_err_apply`

## Requirements
- R1: After reset, `done`, `mem_rd_en` and `mem_wr_en` are low, and no buffer access occurs until a page is started.
- R2: For an odd position p (1 to LAST_POS), pattern bits 11:4 are XORed into byte (3p-1)/2, and pattern bits 3:0 into bits 7:4 of the following byte.
- R3: For an even position p of at least 2, pattern bits 11:8 are XORed into bits 3:0 of byte 3p/2-1, and pattern bits 7:0 into byte 3p/2.
- R4: Position 0 XORs pattern bits 7:0 into byte 0 when pattern bits 11:8 are zero. If any of those four bits is set, the page fails.
- R5: Position 1365 straddles the data/spare boundary: bits 11:4 go to byte 2047 (the last data byte) and bits 3:0 go to bits 7:4 of byte 2048 (the first spare byte).
- R6: Any position above LAST_POS (default 1374) fails the page.
- R7: A failed page performs no buffer write at all, even for its legal pairs, and reports `fail`=1 with `corr_count`=0.
- R8: A page that passes reports `fail`=0 and a `corr_count` equal to its number of pairs. A page with zero pairs finishes with a count of 0 and no buffer access.
- R9: A `start` whose `err_count` exceeds MAX_ERR (4) fails the page without collecting any pairs.
- R10: Every buffer write is preceded in the previous cycle by a read of the same address, and writes the read byte XOR the correction mask. Read and write are never asserted together.
- R11: `pair_valid` outside pair collection, and `start` while a page is in progress, have no effect.
- R12: `done` is a single-cycle pulse, exactly one per started page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a page when idle |
| err_count | input | 3 | Number of pairs that follow `start` |
| pair_valid | input | 1 | Qualifies one (position, pattern) pair |
| pair_pos | input | 11 | Symbol position |
| pair_pat | input | 12 | Error pattern for that symbol |
| mem_addr | output | 12 | Buffer byte address |
| mem_rd_en | output | 1 | Buffer read strobe; data is returned on the next cycle |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_wdata | output | 8 | Corrected byte |
| mem_rdata | input | 8 | Byte read from the buffer, one cycle after `mem_rd_en` |
| done | output | 1 | Page finished |
| fail | output | 1 | Page uncorrectable; valid with `done` |
| corr_count | output | 3 | Number of corrected symbols; valid with `done` |

## Verification
The assertions assume the buffer returns read data exactly one cycle after `mem_rd_en` and holds the written value until the next access. The bench models a single-cycle synchronous memory that meets these assumptions. The assertions also assume the pair count matches the number of `pair_valid` strobes that follow `start`. The bench always sends exactly that many pairs, on consecutive cycles, and only sends extra strobes or starts deliberately while the block is idle or busy, to exercise R11. Expected buffer contents are computed from each symbol's bit offset (12p-4) rather than from the byte formulas, so a wrong mapping shows up as a memory mismatch.

// File: rtl/rs12_pkg.sv
package rs12_pkg;
   localparam int SYM_BITS = 12;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COLLECT,
      ST_CHECK,
      ST_READ,
      ST_WRITE,
      ST_DONE
   } seq_state_t;
endpackage

// File: rtl/rs12_sym_map.sv
// Position-to-byte mapping for one (position, pattern) pair.
module rs12_sym_map #(
   parameter int POS_W    = 11,
   parameter int ADDR_W   = 12,
   parameter int LAST_POS = 1374
) (
   input  logic [POS_W-1:0]            pos,
   input  logic [rs12_pkg::SYM_BITS-1:0] pat,
   output logic [ADDR_W-1:0]           addr_a,
   output logic [ADDR_W-1:0]           addr_b,
   output logic [7:0]                  mask_a,
   output logic [7:0]                  mask_b,
   output logic                        two_bytes,
   output logic                        bad
);
   localparam int TW = POS_W + 2;

   logic [TW-1:0] tri3;
   logic [TW-2:0] half;

   always_comb begin
      tri3      = TW'(pos) + (TW'(pos) << 1);
      half      = tri3[TW-1:1];
      addr_a    = '0;
      addr_b    = '0;
      mask_a    = '0;
      mask_b    = '0;
      two_bytes = 1'b0;
      bad       = (pos > POS_W'(LAST_POS));
      if (pos == '0) begin
         // short leading symbol: only the low eight bits are stored
         mask_a = pat[7:0];
         if (pat[11:8] != 4'h0) bad = 1'b1;
      end else if (pos[0]) begin
         // symbol starts on a byte boundary
         addr_a    = ADDR_W'(half);
         mask_a    = pat[11:4];
         addr_b    = ADDR_W'(half + (TW-1)'(1));
         mask_b    = {pat[3:0], 4'h0};
         two_bytes = 1'b1;
      end else begin
         // symbol starts in the low nibble of the previous byte
         addr_a    = ADDR_W'(half - (TW-1)'(1));
         mask_a    = {4'h0, pat[11:8]};
         addr_b    = ADDR_W'(half);
         mask_b    = pat[7:0];
         two_bytes = 1'b1;
      end
   end
endmodule

// File: rtl/rs12_pair_store.sv
// Holds the pairs of one page until they have all been validated.
module rs12_pair_store #(
   parameter int MAX_ERR = 4,
   parameter int POS_W   = 11,
   parameter int IDX_W   = 2
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      wr_en,
   input  logic [IDX_W-1:0]                          wr_idx,
   input  logic [POS_W-1:0]                          pos_in,
   input  logic [rs12_pkg::SYM_BITS-1:0]             pat_in,
   output logic [MAX_ERR-1:0][POS_W-1:0]             pos_q,
   output logic [MAX_ERR-1:0][rs12_pkg::SYM_BITS-1:0] pat_q
);
   for (genvar s = 0; s < MAX_ERR; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pos_q[s] <= '0;
            pat_q[s] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(s))) begin
            pos_q[s] <= pos_in;
            pat_q[s] <= pat_in;
         end
      end
   end
endmodule

// File: rtl/rs12_rmw_seq.sv
// Page sequencer: collect, validate, then read-modify-write per byte.
module rs12_rmw_seq #(
   parameter int MAX_ERR = 4,
   parameter int ADDR_W  = 12,
   parameter int CNT_W   = 3,
   parameter int IDX_W   = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic [CNT_W-1:0]                  err_count,
   input  logic                              pair_valid,
   input  logic [MAX_ERR-1:0]                bad_vec,
   input  logic [MAX_ERR-1:0]                two_vec,
   input  logic [MAX_ERR-1:0][ADDR_W-1:0]    addr_a_vec,
   input  logic [MAX_ERR-1:0][ADDR_W-1:0]    addr_b_vec,
   input  logic [MAX_ERR-1:0][7:0]           mask_a_vec,
   input  logic [MAX_ERR-1:0][7:0]           mask_b_vec,
   input  logic [7:0]                        mem_rdata,
   output logic                              store_wr,
   output logic [IDX_W-1:0]                  store_idx,
   output logic [ADDR_W-1:0]                 mem_addr,
   output logic                              mem_rd_en,
   output logic                              mem_wr_en,
   output logic [7:0]                        mem_wdata,
   output logic                              done,
   output logic                              fail,
   output logic [CNT_W-1:0]                  corr_count
);
   import rs12_pkg::*;

   seq_state_t        state;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic              half_q;
   logic              fail_q;
   logic [CNT_W-1:0]  corr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        mask_q;

   logic [MAX_ERR-1:0] live;
   logic               fail_now;
   logic               last_slot;
   logic [ADDR_W-1:0]  sel_addr;
   logic [7:0]         sel_mask;

   always_comb begin
      for (int i = 0; i < MAX_ERR; i++) begin
         live[i] = (CNT_W'(i) < cnt_q);
      end
      fail_now  = (cnt_q > CNT_W'(MAX_ERR)) | (|(bad_vec & live));
      last_slot = (CNT_W'(idx_q) == (cnt_q - CNT_W'(1)));
      sel_addr  = half_q ? addr_b_vec[idx_q] : addr_a_vec[idx_q];
      sel_mask  = half_q ? mask_b_vec[idx_q] : mask_a_vec[idx_q];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt_q  <= '0;
         idx_q  <= '0;
         half_q <= 1'b0;
         fail_q <= 1'b0;
         corr_q <= '0;
         addr_q <= '0;
         mask_q <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  cnt_q  <= err_count;
                  idx_q  <= '0;
                  half_q <= 1'b0;
                  fail_q <= 1'b0;
                  corr_q <= '0;
                  if ((err_count == '0) || (err_count > CNT_W'(MAX_ERR)))
                     state <= ST_CHECK;
                  else
                     state <= ST_COLLECT;
               end
            end
            ST_COLLECT: begin
               if (pair_valid) begin
                  if (last_slot) begin
                     idx_q <= '0;
                     state <= ST_CHECK;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            ST_CHECK: begin
               if (fail_now) begin
                  fail_q <= 1'b1;
                  corr_q <= '0;
                  state  <= ST_DONE;
               end else if (cnt_q == '0) begin
                  state  <= ST_DONE;
               end else begin
                  state  <= ST_READ;
               end
            end
            ST_READ: begin
               addr_q <= sel_addr;
               mask_q <= sel_mask;
               state  <= ST_WRITE;
            end
            ST_WRITE: begin
               if (!half_q && two_vec[idx_q]) begin
                  half_q <= 1'b1;
                  state  <= ST_READ;
               end else if (last_slot) begin
                  corr_q <= cnt_q;
                  state  <= ST_DONE;
               end else begin
                  idx_q  <= idx_q + IDX_W'(1);
                  half_q <= 1'b0;
                  state  <= ST_READ;
               end
            end
            ST_DONE:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign store_wr   = (state == ST_COLLECT) && pair_valid;
   assign store_idx  = idx_q;
   assign mem_rd_en  = (state == ST_READ);
   assign mem_wr_en  = (state == ST_WRITE);
   assign mem_addr   = (state == ST_READ) ? sel_addr : addr_q;
   assign mem_wdata  = mem_rdata ^ mask_q;
   assign done       = (state == ST_DONE);
   assign fail       = fail_q;
   assign corr_count = corr_q;
endmodule

// File: rtl/rs12_err_apply.sv
// Top: applies up to MAX_ERR symbol corrections to a page buffer.
module rs12_err_apply #(
   parameter int DATA_BYTES  = 2048,
   parameter int SPARE_BYTES = 64,
   parameter int MAX_ERR     = 4,
   parameter int POS_W       = 11,
   parameter int LAST_POS    = 1374
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [$clog2(MAX_ERR+1)-1:0]  err_count,
   input  logic                          pair_valid,
   input  logic [POS_W-1:0]              pair_pos,
   input  logic [11:0]                   pair_pat,
   output logic [$clog2(DATA_BYTES+SPARE_BYTES)-1:0] mem_addr,
   output logic                          mem_rd_en,
   output logic                          mem_wr_en,
   output logic [7:0]                    mem_wdata,
   input  logic [7:0]                    mem_rdata,
   output logic                          done,
   output logic                          fail,
   output logic [$clog2(MAX_ERR+1)-1:0]  corr_count
);
   localparam int TOTAL_BYTES = DATA_BYTES + SPARE_BYTES;
   localparam int ADDR_W      = $clog2(TOTAL_BYTES);
   localparam int CNT_W       = $clog2(MAX_ERR + 1);
   localparam int IDX_W       = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;
   localparam int TOP_BYTE    = (3 * LAST_POS) / 2 + 1;

   if (MAX_ERR < 1) begin : g_chk_cnt
      $error("MAX_ERR must be at least 1");
   end
   if (LAST_POS >= (1 << POS_W)) begin : g_chk_pos
      $error("LAST_POS does not fit in POS_W bits");
   end
   if (TOP_BYTE >= TOTAL_BYTES) begin : g_chk_span
      $error("LAST_POS reaches beyond the page buffer");
   end

   logic [MAX_ERR-1:0][POS_W-1:0]  pos_q;
   logic [MAX_ERR-1:0][11:0]       pat_q;
   logic [MAX_ERR-1:0][ADDR_W-1:0] addr_a_vec;
   logic [MAX_ERR-1:0][ADDR_W-1:0] addr_b_vec;
   logic [MAX_ERR-1:0][7:0]        mask_a_vec;
   logic [MAX_ERR-1:0][7:0]        mask_b_vec;
   logic [MAX_ERR-1:0]             two_vec;
   logic [MAX_ERR-1:0]             bad_vec;
   logic                           store_wr;
   logic [IDX_W-1:0]               store_idx;

   rs12_pair_store #(
      .MAX_ERR (MAX_ERR),
      .POS_W   (POS_W),
      .IDX_W   (IDX_W)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (store_wr),
      .wr_idx (store_idx),
      .pos_in (pair_pos),
      .pat_in (pair_pat),
      .pos_q  (pos_q),
      .pat_q  (pat_q)
   );

   for (genvar s = 0; s < MAX_ERR; s++) begin : g_map
      rs12_sym_map #(
         .POS_W    (POS_W),
         .ADDR_W   (ADDR_W),
         .LAST_POS (LAST_POS)
      ) u_map (
         .pos       (pos_q[s]),
         .pat       (pat_q[s]),
         .addr_a    (addr_a_vec[s]),
         .addr_b    (addr_b_vec[s]),
         .mask_a    (mask_a_vec[s]),
         .mask_b    (mask_b_vec[s]),
         .two_bytes (two_vec[s]),
         .bad       (bad_vec[s])
      );
   end

   rs12_rmw_seq #(
      .MAX_ERR (MAX_ERR),
      .ADDR_W  (ADDR_W),
      .CNT_W   (CNT_W),
      .IDX_W   (IDX_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .err_count  (err_count),
      .pair_valid (pair_valid),
      .bad_vec    (bad_vec),
      .two_vec    (two_vec),
      .addr_a_vec (addr_a_vec),
      .addr_b_vec (addr_b_vec),
      .mask_a_vec (mask_a_vec),
      .mask_b_vec (mask_b_vec),
      .mem_rdata  (mem_rdata),
      .store_wr   (store_wr),
      .store_idx  (store_idx),
      .mem_addr   (mem_addr),
      .mem_rd_en  (mem_rd_en),
      .mem_wr_en  (mem_wr_en),
      .mem_wdata  (mem_wdata),
      .done       (done),
      .fail       (fail),
      .corr_count (corr_count)
   );
endmodule

// File: rtl/rs12_err_apply_chk.sv
module rs12_err_apply_chk #(
   parameter int MAX_ERR = 4,
   parameter int ADDR_W  = 12,
   parameter int CNT_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd_en,
   input logic              mem_wr_en,
   input logic              done,
   input logic              fail,
   input logic [CNT_W-1:0]  corr_count
);
   logic wrote_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wrote_q <= 1'b0;
      else if (done)      wrote_q <= 1'b0;
      else if (mem_wr_en) wrote_q <= 1'b1;
   end

   assert_rw_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd_en, mem_wr_en}));

   assert_wr_after_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ($past(mem_rd_en) && (mem_addr == $past(mem_addr))));

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_fail_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fail) |-> (corr_count == '0));

   assert_no_write_on_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fail) |-> !wrote_q);

   assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fail) |-> (corr_count <= CNT_W'(MAX_ERR)));

   assert_no_access_at_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mem_rd_en && !mem_wr_en));
endmodule

bind rs12_err_apply rs12_err_apply_chk #(
   .MAX_ERR (MAX_ERR),
   .ADDR_W  (ADDR_W),
   .CNT_W   (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_addr   (mem_addr),
   .mem_rd_en  (mem_rd_en),
   .mem_wr_en  (mem_wr_en),
   .done       (done),
   .fail       (fail),
   .corr_count (corr_count)
);

// File: tb/rs12_err_apply_tb_top.sv
`timescale 1ns/1ps
module rs12_err_apply_tb_top;
   localparam int TOTAL = 2112;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  err_count = '0;
   logic        pair_valid = 1'b0;
   logic [10:0] pair_pos = '0;
   logic [11:0] pair_pat = '0;
   logic [11:0] mem_addr;
   logic        mem_rd_en, mem_wr_en;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        done, fail;
   logic [2:0]  corr_count;

   logic [7:0]  mem     [TOTAL];
   logic [7:0]  exp_mem [TOTAL];
   int          t_pos [4];
   logic [11:0] t_pat [4];
   int          n_tot = 0;
   int          n_fail = 0;
   logic        prev_rd = 1'b0;
   logic [11:0] prev_addr = '0;
   logic        finished = 1'b0;

   always #10 clk = ~clk;

   rs12_err_apply dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .err_count(err_count),
      .pair_valid(pair_valid), .pair_pos(pair_pos), .pair_pat(pair_pat),
      .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .done(done), .fail(fail), .corr_count(corr_count)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_tot++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // single-cycle synchronous buffer model and access-order monitor
   always @(posedge clk) begin
      if (rst_n && mem_wr_en)
         chk(prev_rd && (prev_addr == mem_addr), "R10", "write without matching read",
             int'(mem_addr), int'(prev_addr));
      if (rst_n && mem_rd_en && mem_wr_en)
         chk(1'b0, "R10", "read and write together", 1, 0);
      prev_rd   <= mem_rd_en;
      prev_addr <= mem_addr;
      if (mem_rd_en && (int'(mem_addr) < TOTAL)) mem_rdata <= mem[mem_addr];
      if (mem_wr_en && (int'(mem_addr) < TOTAL)) mem[mem_addr] <= mem_wdata;
   end

   // bit-level expectation: symbol p>0 occupies buffer bits 12p-4 .. 12p+7
   task automatic exp_apply(input int p, input logic [11:0] pat);
      for (int k = 0; k < 12; k++) begin
         int g;
         if (p == 0) begin
            if (k < 4) continue;
            g = k - 4;
         end else begin
            g = 12 * p - 4 + k;
         end
         exp_mem[g >> 3][7 - (g & 7)] ^= pat[11 - k];
      end
   endtask

   task automatic cmp_mem(input string req);
      int bad_at = -1;
      for (int i = 0; i < TOTAL; i++) begin
         if (mem[i] !== exp_mem[i] && bad_at < 0) bad_at = i;
      end
      if (bad_at < 0) chk(1'b1, req, "buffer", 0, 0);
      else chk(1'b0, req, $sformatf("buffer byte %0d", bad_at),
               int'(mem[bad_at]), int'(exp_mem[bad_at]));
   endtask

   task automatic run_page(input int n, input string req, input bit poke_start);
      bit ok;
      bit got = 1'b0;
      ok = (n <= 4);
      for (int i = 0; i < n && i < 4; i++) begin
         if (t_pos[i] > 1374) ok = 1'b0;
         if (t_pos[i] == 0 && t_pat[i][11:8] != 4'h0) ok = 1'b0;
      end
      if (ok) for (int i = 0; i < n; i++) exp_apply(t_pos[i], t_pat[i]);
      @(negedge clk);
      start = 1'b1; err_count = 3'(n);
      @(negedge clk);
      start = 1'b0; err_count = '0;
      if (n <= 4) begin
         for (int i = 0; i < n; i++) begin
            pair_valid = 1'b1; pair_pos = 11'(t_pos[i]); pair_pat = t_pat[i];
            if (i == n - 1) begin
               @(negedge clk);
               pair_valid = 1'b0;
               if (done) got = 1'b1;
            end else begin
               @(negedge clk);
            end
         end
      end
      if (poke_start) begin
         start = 1'b1; err_count = 3'd5;
         @(negedge clk);
         start = 1'b0; err_count = '0;
      end
      for (int c = 0; c < 200 && !got; c++) begin
         if (done) got = 1'b1;
         else @(negedge clk);
      end
      chk(got, req, "done seen", int'(got), 1);
      if (got) begin
         chk(fail == !ok, req, "fail flag", int'(fail), int'(!ok));
         chk(int'(corr_count) == (ok ? n : 0), req, "corr_count",
             int'(corr_count), ok ? n : 0);
         @(negedge clk);
         chk(!done, "R12", "done width", int'(done), 0);
      end
      cmp_mem(req);
   endtask

   initial begin
      for (int i = 0; i < TOTAL; i++) begin
         mem[i]     = 8'((i * 7) ^ 8'h3C);
         exp_mem[i] = 8'((i * 7) ^ 8'h3C);
      end
      repeat (3) @(negedge clk);
      chk(!done && !mem_rd_en && !mem_wr_en, "R1", "outputs in reset",
          int'({done, mem_rd_en, mem_wr_en}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!done && !mem_rd_en && !mem_wr_en, "R1", "idle after reset",
          int'({done, mem_rd_en, mem_wr_en}), 0);

      // sweep every legal position with a single error
      for (int p = 0; p <= 1374; p++) begin
         string req;
         t_pos[0] = p;
         t_pat[0] = (p == 0) ? 12'h0A5 : 12'(p * 1103 + 291);
         if (p == 0) req = "R4";
         else if (p == 1365) req = "R5";
         else if (p[0]) req = "R2";
         else req = "R3";
         run_page(1, req, 1'b0);
      end

      // out-of-range positions
      for (int p = 1375; p <= 1380; p++) begin
         t_pos[0] = p; t_pat[0] = 12'hFFF;
         run_page(1, "R6", 1'b0);
      end
      t_pos[0] = 2047; t_pat[0] = 12'h001;
      run_page(1, "R6", 1'b0);

      // position 0 with upper bits set
      t_pos[0] = 0; t_pat[0] = 12'h1A5;
      run_page(1, "R4", 1'b0);

      // four errors including both boundary cases
      t_pos[0] = 1; t_pos[1] = 2; t_pos[2] = 1365; t_pos[3] = 1374;
      t_pat[0] = 12'hABC; t_pat[1] = 12'h123; t_pat[2] = 12'hF0F; t_pat[3] = 12'h5A5;
      run_page(4, "R8", 1'b0);
      t_pos[0] = 0; t_pos[1] = 700; t_pos[2] = 701; t_pos[3] = 1366;
      t_pat[0] = 12'h0FF; t_pat[1] = 12'hFFF; t_pat[2] = 12'h801; t_pat[3] = 12'h3C3;
      run_page(4, "R8", 1'b0);
      t_pos[0] = 1364; t_pos[1] = 1365; t_pos[2] = 1367;
      t_pat[0] = 12'h111; t_pat[1] = 12'h222; t_pat[2] = 12'h333;
      run_page(3, "R5", 1'b0);

      // zero pairs
      run_page(0, "R8", 1'b0);

      // legal pairs followed by an illegal one: nothing may be written
      t_pos[0] = 10; t_pos[1] = 20; t_pos[2] = 30; t_pos[3] = 1400;
      t_pat[0] = 12'hFFF; t_pat[1] = 12'hFFF; t_pat[2] = 12'hFFF; t_pat[3] = 12'h001;
      run_page(4, "R7", 1'b0);
      t_pos[0] = 0; t_pos[1] = 5; t_pat[0] = 12'h800; t_pat[1] = 12'h777;
      run_page(2, "R7", 1'b0);

      // too many errors
      run_page(5, "R9", 1'b0);
      run_page(7, "R9", 1'b0);

      // stray pairs while idle, then an empty page
      @(negedge clk);
      pair_valid = 1'b1; pair_pos = 11'd5; pair_pat = 12'hFFF;
      repeat (3) @(negedge clk);
      pair_valid = 1'b0;
      chk(!mem_wr_en && !done, "R11", "idle pair_valid", int'({mem_wr_en, done}), 0);
      run_page(0, "R11", 1'b0);

      // start while busy must be ignored
      t_pos[0] = 3; t_pos[1] = 4; t_pos[2] = 900; t_pos[3] = 1001;
      t_pat[0] = 12'h456; t_pat[1] = 12'h789; t_pat[2] = 12'hCDE; t_pat[3] = 12'h0F1;
      run_page(4, "R11", 1'b1);
      begin
         bit extra = 1'b0;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (done) extra = 1'b1;
         end
         chk(!extra, "R11", "second done after busy start", int'(extra), 0);
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tot++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
         $finish;
      end
   end
endmodule